// File: doc/BRIEF.md
# Disk Adapter Completion Status Reporter

This block holds the completion status of a disk adapter command until the host has read it. The adapter's command logic stages payload words into a small buffer and then pulses a load strobe with the command code, the device select, the block length, the completion outcome and a block kind. The block builds the header word itself and sets the status-out-full flag and the interrupt flag. It also sets an interrupt status byte made from the device select and a completion code. The host then reads the block one 16-bit word per read strobe until it is drained.

Two error blocks have fixed content: one for a command the adapter does not support and one for a drive that is absent. The hardware produces these on the fly when they are read, so the command logic only has to name the kind. A load that arrives while a block is still waiting to be drained is refused and flagged, and the waiting block is kept as it was. The interrupt line to the host is gated by an enable input.

Top module: `dsk_status_reporter`

## Requirements
- R1: Word 0 of every block is the header: bits 4:0 hold `ld_cmd`, bits 7:5 hold `ld_dev` (7 = adapter, 0 or 1 = drive), and bits 15:8 hold the block length in words.
- R2: With `ld_kind` = 1 (unsupported command) the block is 9 words long. Word 1 is 0x0F03, word 2 is 0x0002, and words 3 to 8 are zero.
- R3: With `ld_kind` = 2 (drive absent) the block is 9 words long. Word 1 is 0x0C11, word 2 is 0x000B, and words 3 to 8 are zero.
- R4: An accepted load sets `basic_status` bit 3 (out full) and bit 0 (interrupt) after the same clock edge; the other bits of `basic_status` stay zero. `irq_code` becomes {`ld_dev`, 1'b0, code}, where code is 0x1 for a custom block loaded with `ld_ok` = 1 and 0xC for every other load.
- R5: With `ld_kind` = 0 or 3 (custom), the payload words 1 to length-1 come from the last writes made through `pay_we`/`pay_idx`/`pay_data`. Each `rd_stb` while out full puts the next word on `rd_data` after that edge. The read of the last word clears out full.
- R6: An `rd_stb` while out full is clear puts zero on `rd_data`. `rd_data` holds its value between read strobes.
- R7: `irq_out` is registered and equals the interrupt flag AND `irq_en` as sampled at the same edge.
- R8: An `ld_valid` while out full is refused: the waiting block is read out unchanged, and `proto_err` is set. `proto_err` stays set until the next accepted load, which clears it.
- R9: `pay_we` writes made while out full are ignored and do not alter the payload of a later custom block.
- R10: `irq_ack` clears the interrupt flag. A load accepted in the same cycle wins, and the flag stays set.
- R11: A custom load with `ld_len` = 0 gives a one-word block, and its header reports length 1.
- R12: After reset `rd_data` is 0, `basic_status` is 0, `irq_code` is 0xFF, and `irq_out` and `proto_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_en | input | 1 | Interrupt enable from the control register |
| ld_valid | input | 1 | Load strobe from the command logic |
| ld_kind | input | 2 | Block kind: 0/3 custom, 1 unsupported, 2 drive absent |
| ld_cmd | input | 5 | Command code for the header |
| ld_dev | input | 3 | Device select for the header and interrupt code |
| ld_len | input | 4 | Custom block length in words (0 is taken as 1) |
| ld_ok | input | 1 | Custom block completed with success |
| pay_we | input | 1 | Payload word write enable |
| pay_idx | input | 4 | Payload word index |
| pay_data | input | 16 | Payload word |
| rd_stb | input | 1 | Host word read of the status interface register |
| irq_ack | input | 1 | End-of-interrupt from the host |
| rd_data | output | 16 | Last word read |
| basic_status | output | 8 | Bit 3 out full, bit 0 interrupt |
| irq_code | output | 8 | Interrupt status byte |
| irq_out | output | 1 | Gated interrupt line |
| proto_err | output | 1 | A load was refused while a block was waiting |

## Verification
The hardest situation to reach is a refused load, or a payload write, that lands while a block is only partly drained. Only then can the bench tell a kept block from an overwritten one. Directed sequences load a block, read part of it, and then fire a load and stray payload writes before finishing the drain. They also put the last read, an acknowledge and a fresh load on the same edge. Random traffic with a high read rate and a fixed seed then mixes these overlaps across all kinds and lengths. A bench model predicts every word.

// File: rtl/dskrpt_pkg.sv
package dskrpt_pkg;
  localparam int WORD_W = 16;
  localparam int ERR_LEN = 9;  // fixed error blocks; DEPTH must exceed this

  typedef enum logic [1:0] {
    BLK_CUSTOM = 2'd0,
    BLK_UNSUP  = 2'd1,
    BLK_ABSENT = 2'd2,
    BLK_ALT    = 2'd3
  } blk_kind_t;

  typedef enum logic [1:0] {
    SRC_ZERO  = 2'd0,
    SRC_HDR   = 2'd1,
    SRC_RAM   = 2'd2,
    SRC_FIXED = 2'd3
  } rd_src_t;

  localparam logic [3:0] CC_SUCCESS = 4'h1;
  localparam logic [3:0] CC_FAILURE = 4'hC;

  function automatic logic is_err_kind(input blk_kind_t k);
    return (k == BLK_UNSUP) || (k == BLK_ABSENT);
  endfunction
endpackage

// File: rtl/rpt_payload_ram.sv
module rpt_payload_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  // Simple dual port, registered read with enable: maps to block RAM.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rpt_fixed_words.sv
module rpt_fixed_words
  import dskrpt_pkg::*;
#(
  parameter int AW = 4
) (
  input  blk_kind_t         kind,
  input  logic [AW-1:0]     idx,
  output logic [WORD_W-1:0] word
);
  // Content of the two hardware-built error blocks, words 1..8.
  always_comb begin
    word = '0;
    if (kind == BLK_UNSUP) begin
      if (idx == AW'(1)) word = 16'h0F03;
      else if (idx == AW'(2)) word = 16'h0002;
    end else if (kind == BLK_ABSENT) begin
      if (idx == AW'(1)) word = 16'h0C11;
      else if (idx == AW'(2)) word = 16'h000B;
    end
  end
endmodule

// File: rtl/rpt_drain_ctrl.sv
module rpt_drain_ctrl
  import dskrpt_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_en,
  input  logic              ld_valid,
  input  blk_kind_t         ld_kind,
  input  logic [4:0]        ld_cmd,
  input  logic [2:0]        ld_dev,
  input  logic [AW-1:0]     ld_len,
  input  logic              ld_ok,
  input  logic              rd_stb,
  input  logic              irq_ack,
  output logic              full_q,
  output logic              irq_q,
  output logic [7:0]        code_q,
  output logic              perr_q,
  output logic              irq_out_q,
  output logic [AW-1:0]     ptr_q,
  output blk_kind_t         kind_q,
  output logic [WORD_W-1:0] hdr_q,
  output rd_src_t           rd_src
);
  logic [AW-1:0] len_q;
  logic          accept, rd_go, rd_last, irq_d;
  logic [AW-1:0] eff_len;
  logic [3:0]    cc;

  assign accept  = ld_valid && !full_q;
  assign rd_go   = rd_stb && full_q;
  assign rd_last = rd_go && (ptr_q == len_q - AW'(1));
  assign eff_len = is_err_kind(ld_kind) ? AW'(ERR_LEN)
                 : (ld_len == '0) ? AW'(1) : ld_len;
  assign cc      = (!is_err_kind(ld_kind) && ld_ok) ? CC_SUCCESS : CC_FAILURE;
  assign irq_d   = accept ? 1'b1 : (irq_ack ? 1'b0 : irq_q);

  // Source of the word returned by the current read strobe.
  always_comb begin
    if (!full_q)             rd_src = SRC_ZERO;
    else if (ptr_q == '0)    rd_src = SRC_HDR;
    else if (is_err_kind(kind_q)) rd_src = SRC_FIXED;
    else                     rd_src = SRC_RAM;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q    <= 1'b0;
      irq_q     <= 1'b0;
      code_q    <= 8'hFF;
      perr_q    <= 1'b0;
      irq_out_q <= 1'b0;
      ptr_q     <= '0;
      len_q     <= '0;
      kind_q    <= BLK_CUSTOM;
      hdr_q     <= '0;
    end else begin
      irq_q     <= irq_d;
      irq_out_q <= irq_d && irq_en;
      if (accept) begin
        full_q <= 1'b1;
        ptr_q  <= '0;
        len_q  <= eff_len;
        kind_q <= ld_kind;
        hdr_q  <= {8'(eff_len), ld_dev, ld_cmd};
        code_q <= {ld_dev, 1'b0, cc};
        perr_q <= 1'b0;
      end else begin
        if (ld_valid) perr_q <= 1'b1;
        if (rd_last) begin
          full_q <= 1'b0;
          ptr_q  <= '0;
          len_q  <= '0;
        end else if (rd_go) begin
          ptr_q <= ptr_q + AW'(1);
        end
      end
    end
  end

  a_r5_empty_len_zero: assert property (@(posedge clk) disable iff (rst)
    !full_q |-> (len_q == '0 && ptr_q == '0));
  a_r5_ptr_in_block: assert property (@(posedge clk) disable iff (rst)
    full_q |-> (ptr_q < len_q));
  a_r4_load_raises: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !full_q) |=> (full_q && irq_q));
  a_r8_reject_flags: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && full_q) |=> perr_q);
  a_r8_reject_keeps_hdr: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && full_q) |=> $stable(hdr_q));
  a_r7_irq_gated: assert property (@(posedge clk) disable iff (rst)
    irq_out_q |-> irq_q);
  a_r10_load_beats_ack: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !full_q && irq_ack) |=> irq_q);
endmodule

// File: rtl/dsk_status_reporter.sv
module dsk_status_reporter
  import dskrpt_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              irq_en,
  input  logic              ld_valid,
  input  logic [1:0]        ld_kind,
  input  logic [4:0]        ld_cmd,
  input  logic [2:0]        ld_dev,
  input  logic [AW-1:0]     ld_len,
  input  logic              ld_ok,
  input  logic              pay_we,
  input  logic [AW-1:0]     pay_idx,
  input  logic [WORD_W-1:0] pay_data,
  input  logic              rd_stb,
  input  logic              irq_ack,
  output logic [WORD_W-1:0] rd_data,
  output logic [7:0]        basic_status,
  output logic [7:0]        irq_code,
  output logic              irq_out,
  output logic              proto_err
);
  logic              full_q, irq_q;
  logic [AW-1:0]     ptr_q;
  blk_kind_t         kind_q;
  logic [WORD_W-1:0] hdr_q, ram_q, fix_w, fix_q, hdr_hold_q;
  rd_src_t           rd_src, src_q;

  rpt_drain_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk, .rst, .irq_en, .ld_valid,
    .ld_kind(blk_kind_t'(ld_kind)), .ld_cmd, .ld_dev, .ld_len, .ld_ok,
    .rd_stb, .irq_ack,
    .full_q, .irq_q, .code_q(irq_code), .perr_q(proto_err),
    .irq_out_q(irq_out), .ptr_q, .kind_q, .hdr_q, .rd_src
  );

  // Payload writes are locked out while a block waits to be drained.
  rpt_payload_ram #(.DEPTH(DEPTH), .W(WORD_W)) u_ram (
    .clk, .we(pay_we && !full_q), .waddr(pay_idx), .wdata(pay_data),
    .re(rd_stb), .raddr(ptr_q), .rdata(ram_q)
  );

  rpt_fixed_words #(.AW(AW)) u_fixed (
    .kind(kind_q), .idx(ptr_q), .word(fix_w)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q      <= SRC_ZERO;
      fix_q      <= '0;
      hdr_hold_q <= '0;
    end else if (rd_stb) begin
      src_q      <= rd_src;
      fix_q      <= fix_w;
      hdr_hold_q <= hdr_q;
    end
  end

  always_comb begin
    unique case (src_q)
      SRC_HDR:   rd_data = hdr_hold_q;
      SRC_RAM:   rd_data = ram_q;
      SRC_FIXED: rd_data = fix_q;
      default:   rd_data = '0;
    endcase
  end

  assign basic_status = {4'b0000, full_q, 2'b00, irq_q};

  a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !full_q) |=> (rd_data == '0));
  a_r6_hold_between_reads: assert property (@(posedge clk) disable iff (rst)
    (!rd_stb && !$past(rst)) |=> $stable(rd_data));
  a_r1_header_first: assert property (@(posedge clk) disable iff (rst)
    (ld_valid && !full_q) |=> (hdr_q[4:0] == $past(ld_cmd) && hdr_q[7:5] == $past(ld_dev)));
endmodule

// File: tb/tb_dsk_status_reporter.sv
module tb_dsk_status_reporter;
  localparam int CLK_PERIOD = 10;
  localparam int D = 16;

  logic clk = 0, rst = 1;
  logic irq_en = 0, ld_valid = 0, ld_ok = 0, pay_we = 0, rd_stb = 0, irq_ack = 0;
  logic [1:0] ld_kind = 0;
  logic [4:0] ld_cmd = 0;
  logic [2:0] ld_dev = 0;
  logic [3:0] ld_len = 0, pay_idx = 0;
  logic [15:0] pay_data = 0;
  logic [15:0] rd_data;
  logic [7:0] basic_status, irq_code;
  logic irq_out, proto_err;

  int vectors = 0, errors = 0;
  string tag = "R5";

  // model state
  logic m_full = 0, m_irq = 0, m_perr = 0, m_iout = 0;
  logic [7:0] m_code = 8'hFF;
  int m_len = 0, m_ptr = 0;
  logic [15:0] m_blk [D];
  logic [15:0] m_pay [D];
  logic [15:0] m_rd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dsk_status_reporter dut (.*);

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h at %0t", req, got, exp, $time);
    end
  endtask

  function automatic logic [15:0] fixed_word(input int k, input int i);
    if (i == 1) return (k == 1) ? 16'h0F03 : 16'h0C11;
    if (i == 2) return (k == 1) ? 16'h0002 : 16'h000B;
    return 16'h0000;
  endfunction

  // Apply one cycle of inputs, update model, sample at following negedge.
  task automatic step(input logic lv, input int kd, input int cm, input int dv,
                      input int ln, input logic ok, input logic rd, input logic we,
                      input int wi, input logic [15:0] wd, input logic ak, input logic en);
    logic err;
    int len;
    ld_valid = lv; ld_kind = 2'(kd); ld_cmd = 5'(cm); ld_dev = 3'(dv); ld_len = 4'(ln);
    ld_ok = ok; rd_stb = rd; pay_we = we; pay_idx = 4'(wi); pay_data = wd;
    irq_ack = ak; irq_en = en;
    @(posedge clk);
    if (we && !m_full) m_pay[wi] = wd;
    if (rd) m_rd = m_full ? m_blk[m_ptr] : 16'h0;
    if (lv && !m_full) begin
      err = (kd == 1 || kd == 2);
      len = err ? 9 : ((ln == 0) ? 1 : ln);
      m_blk[0] = {8'(len), 3'(dv), 5'(cm)};
      for (int i = 1; i < D; i++) m_blk[i] = err ? fixed_word(kd, i) : m_pay[i];
      m_full = 1; m_len = len; m_ptr = 0; m_irq = 1; m_perr = 0;
      m_code = {3'(dv), 1'b0, (!err && ok) ? 4'h1 : 4'hC};
    end else begin
      if (rd && m_full) begin
        if (m_ptr == m_len - 1) begin m_full = 0; m_ptr = 0; m_len = 0; end
        else m_ptr++;
      end
      if (lv) m_perr = 1;
      if (ak) m_irq = 0;
    end
    m_iout = m_irq & en;
    @(negedge clk);
    check(tag, rd_data, m_rd);
    check("R4 status", {8'h0, basic_status}, {12'h0, m_full, 2'b00, m_irq});
    check("R4 irq_code", {8'h0, irq_code}, {8'h0, m_code});
    check("R7 irq_out", {15'h0, irq_out}, {15'h0, m_iout});
    check("R8 proto_err", {15'h0, proto_err}, {15'h0, m_perr});
  endtask

  task automatic idle(input logic rd);
    step(0, 0, 0, 0, 0, 0, rd, 0, 0, 16'h0, 0, 1);
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) idle(1);
  endtask

  initial begin
    for (int i = 0; i < D; i++) begin m_pay[i] = 0; m_blk[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R12 reset state
    check("R12 rd_data", rd_data, 16'h0);
    check("R12 status", {8'h0, basic_status}, 16'h0);
    check("R12 irq_code", {8'h0, irq_code}, 16'h00FF);
    check("R12 irq_out", {15'h0, irq_out}, 16'h0);
    check("R12 proto_err", {15'h0, proto_err}, 16'h0);
    // RAM contents undefined until written; fill the payload
    for (int i = 0; i < D; i++) step(0, 0, 0, 0, 0, 0, 0, 1, i, 16'hA000 + 16'(i), 0, 1);
    // R6 read when empty
    tag = "R6"; idle(1);
    // R2 unsupported block
    tag = "R2"; step(1, 1, 5'h13, 7, 0, 1, 0, 0, 0, 0, 0, 1); drain(9);
    // R3 absent drive, interrupt disabled (R7)
    tag = "R3"; step(1, 2, 5'h01, 1, 0, 1, 0, 0, 0, 0, 0, 0); drain(9);
    tag = "R6"; idle(1); idle(0);
    // R1/R5 custom block of 5 words, success
    tag = "R1"; step(1, 0, 5'h0A, 7, 5, 1, 0, 0, 0, 0, 0, 1); idle(1);
    tag = "R5"; drain(4);
    // R8 refused load mid drain, R9 stray write
    tag = "R8"; step(1, 0, 5'h02, 0, 4, 1, 0, 0, 0, 0, 0, 1); idle(1);
    step(1, 1, 5'h03, 1, 0, 0, 1, 1, 2, 16'hDEAD, 0, 1);
    drain(2);
    tag = "R9"; step(1, 3, 5'h04, 0, 3, 0, 0, 0, 0, 0, 0, 1); drain(3);
    // R10 ack with load in the same cycle, then plain ack
    tag = "R10"; step(1, 0, 5'h05, 1, 2, 1, 0, 0, 0, 0, 1, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1); drain(2);
    // last read, load and ack on one edge: load refused
    step(1, 0, 5'h06, 0, 1, 1, 0, 0, 0, 0, 0, 1);
    step(1, 2, 5'h07, 0, 0, 0, 1, 0, 0, 0, 1, 1); idle(1);
    // R11 zero length custom block
    tag = "R11"; step(1, 0, 5'h08, 0, 0, 1, 0, 0, 0, 0, 0, 1); drain(2);
    // random traffic
    tag = "R5";
    void'($urandom(32'd2024));
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom % 100);
      step(r < 12, int'($urandom % 4), int'($urandom % 32), int'($urandom % 8),
           int'($urandom % 16), 1'($urandom), ($urandom % 100) < 60,
           ($urandom % 100) < 25, int'($urandom % 16), 16'($urandom),
           ($urandom % 100) < 10, ($urandom % 100) < 80);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule